// File: doc/BRIEF.md
# Processor Wait-Mode Clock Controller

This block produces the gated-clock enables of a small processor core. It drives three groups of enables: a set of pipeline enables, one enable for the core peripherals, and one enable per local-memory port. The core can be put to sleep in two ways, and the two ways shut down different amounts of the clock tree. The first way is an external stall input. Under stall the pipeline enables drop, except for the lowest `STALL_KEEP` lanes. The peripherals and the memory ports stay clocked.

The second way is a wait-for-interrupt request from the executing instruction. It is accepted only when the pipeline reports that it has drained. Entry then passes through a one-cycle entry state and reaches a dormant state. In the dormant state every pipeline enable and the peripheral enable are off, and a status output reports the mode. An enabled pending interrupt wakes the core. After wake-up the stall input is looked at again, and the core goes to the stalled state if stall is still high. While the core is dormant, an external bus master can still reach local memory: a pending inbound access on a port raises that port's enable.

All enables and the status output come from flip-flops that are loaded at the rising clock edge. There is no combinational path from any input to any enable. Each enable changes on the clock edge that follows the input change that causes it.

Top module: `wait_clk_ctrl`

## Requirements
- R1: While reset is held and just after it, the block is in the run state. All pipeline enables, the peripheral enable and all memory-port enables are 1, and `wait_mode_o` is 0.
- R2: In the run state a request can be accepted. The request is accepted on an edge where `stall_i` is 0, `wait_req_i` is 1, `drained_i` is 1 and no enabled interrupt is pending. After that edge the block is in the entry state: all pipeline enables 0, the peripheral enable 1, all memory enables 1, and `wait_mode_o` 0.
- R3: In the run state, a wait request has no effect when `drained_i` is 0. It also has no effect when any bit of `irq_pending_i & irq_enable_i` is 1. In either case all pipeline enables stay 1.
- R4: The entry state always moves to the dormant state on the next edge. The dormant state has all pipeline enables 0, the peripheral enable 0 and `wait_mode_o` 1.
- R5: Memory enables in the dormant state depend on `mem_req_i`. After each edge that leaves the block dormant, memory enable bit p equals `mem_req_i[p]` as sampled on that edge. In every other state all memory enables are 1.
- R6: In the dormant state the block wakes when an enabled interrupt is pending. It leaves the dormant state on the first edge where `irq_pending_i & irq_enable_i` is nonzero, and `wait_mode_o` falls after that same edge. A pending interrupt whose enable bit is 0 does not wake the block.
- R7: On the wake edge, if `stall_i` is 1 the block enters the stalled state, otherwise it enters the run state.
- R8: In the run state, `stall_i` = 1 moves the block to the stalled state on the next edge. In the stalled state pipeline lanes below `STALL_KEEP` are 1, the higher lanes are 0, and the peripheral and memory enables are 1. `stall_i` = 0 in the stalled state returns the block to the run state on the next edge.
- R9: `stall_i` has no effect in the entry and dormant states. Its value changes no output there.
- R10: In the run state, `stall_i` = 1 takes priority over an acceptable wait request, and the block goes to the stalled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | External stall request |
| wait_req_i | input | 1 | Wait-for-interrupt request from the executing instruction |
| drained_i | input | 1 | Pipeline reports it holds no work in flight |
| irq_pending_i | input | NUM_IRQ | Pending interrupt lines |
| irq_enable_i | input | NUM_IRQ | Per-line interrupt enable mask |
| mem_req_i | input | NUM_MEM | Inbound access pending, one bit per local-memory port |
| pipe_en_o | output | NUM_PIPE | Pipeline clock-domain enables |
| periph_en_o | output | 1 | Core peripheral clock enable |
| mem_en_o | output | NUM_MEM | Local-memory port clock enables |
| wait_mode_o | output | 1 | High while the core is dormant |

## Verification
The hardest sequence to reach from the ports is a wake-up in which the interrupt arrives while the stall input is already high. In that sequence the stall must have been ignored for several dormant cycles, and the memory requests must have been toggling during that time. The directed stimulus first produces a clean entry: the pipeline is drained, no enabled interrupt is pending, and only masked interrupts are raised. It then holds the core dormant while it toggles the stall and memory-request inputs. After that it fires a masked interrupt line, which must not wake the core, and then an enabled line with stall high. A long pseudo-random walk follows, with wait requests frequent and interrupts rare. This keeps the walk cycling through every state transition, and a behavioural model checks every cycle of it.

// File: rtl/wait_clk_pkg.sv
package wait_clk_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_STALLED  = 2'd1,
    ST_ENTERING = 2'd2,
    ST_WAIT     = 2'd3
  } wm_state_e;
endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pending_i,
  input  logic [NUM_IRQ-1:0] irq_enable_i,
  output logic               wake_o
);
  assign wake_o = |(irq_pending_i & irq_enable_i);
endmodule

// File: rtl/wait_fsm.sv
module wait_fsm
  import wait_clk_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      stall_i,
  input  logic      wait_req_i,
  input  logic      drained_i,
  input  logic      wake_i,
  output wm_state_e state_d_o
);
  wm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        // stall wins over a wait request
        if (stall_i)                                   state_d = ST_STALLED;
        else if (wait_req_i && drained_i && !wake_i)   state_d = ST_ENTERING;
      end
      ST_STALLED:  if (!stall_i) state_d = ST_RUN;
      ST_ENTERING: state_d = ST_WAIT;
      ST_WAIT:     if (wake_i) state_d = stall_i ? ST_STALLED : ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
endmodule

// File: rtl/clk_en_regs.sv
module clk_en_regs
  import wait_clk_pkg::*;
#(
  parameter int NUM_PIPE   = 4,
  parameter int STALL_KEEP = 1,
  parameter int NUM_MEM    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wm_state_e           state_d_i,
  input  logic [NUM_MEM-1:0]  mem_req_i,
  output logic [NUM_PIPE-1:0] pipe_en_o,
  output logic                periph_en_o,
  output logic [NUM_MEM-1:0]  mem_en_o,
  output logic                wait_mode_o
);
  localparam logic [NUM_PIPE-1:0] ALL_PIPE  = {NUM_PIPE{1'b1}};
  localparam logic [NUM_PIPE-1:0] KEEP_MASK = ALL_PIPE >> (NUM_PIPE - STALL_KEEP);

  logic [NUM_PIPE-1:0] pipe_d;
  logic                sleep_d;

  always_comb begin
    unique case (state_d_i)
      ST_RUN:     pipe_d = ALL_PIPE;
      ST_STALLED: pipe_d = KEEP_MASK;
      default:    pipe_d = '0;
    endcase
  end

  assign sleep_d = (state_d_i == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_en_o   <= ALL_PIPE;
      periph_en_o <= 1'b1;
      wait_mode_o <= 1'b0;
    end else begin
      pipe_en_o   <= pipe_d;
      periph_en_o <= !sleep_d;
      wait_mode_o <= sleep_d;
    end
  end

  // per-port enable: forced on outside WAIT, request-driven inside
  for (genvar p = 0; p < NUM_MEM; p++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_en_o[p] <= 1'b1;
      else         mem_en_o[p] <= !sleep_d || mem_req_i[p];
    end
  end
endmodule

// File: rtl/wait_clk_ctrl.sv
module wait_clk_ctrl
  import wait_clk_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_PIPE   = 4,
  parameter int STALL_KEEP = 1,  // must be below NUM_PIPE
  parameter int NUM_MEM    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                stall_i,
  input  logic                wait_req_i,
  input  logic                drained_i,
  input  logic [NUM_IRQ-1:0]  irq_pending_i,
  input  logic [NUM_IRQ-1:0]  irq_enable_i,
  input  logic [NUM_MEM-1:0]  mem_req_i,
  output logic [NUM_PIPE-1:0] pipe_en_o,
  output logic                periph_en_o,
  output logic [NUM_MEM-1:0]  mem_en_o,
  output logic                wait_mode_o
);
  logic      wake;
  wm_state_e state_d;

  wake_detect #(.NUM_IRQ(NUM_IRQ)) i_wake (
    .irq_pending_i(irq_pending_i),
    .irq_enable_i (irq_enable_i),
    .wake_o       (wake)
  );

  wait_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall_i),
    .wait_req_i(wait_req_i),
    .drained_i (drained_i),
    .wake_i    (wake),
    .state_d_o (state_d)
  );

  clk_en_regs #(
    .NUM_PIPE  (NUM_PIPE),
    .STALL_KEEP(STALL_KEEP),
    .NUM_MEM   (NUM_MEM)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .mem_req_i  (mem_req_i),
    .pipe_en_o  (pipe_en_o),
    .periph_en_o(periph_en_o),
    .mem_en_o   (mem_en_o),
    .wait_mode_o(wait_mode_o)
  );
endmodule

// File: rtl/wait_clk_ctrl_chk.sv
module wait_clk_ctrl_chk #(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_PIPE   = 4,
  parameter int STALL_KEEP = 1,
  parameter int NUM_MEM    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                stall_i,
  input logic                wait_req_i,
  input logic                drained_i,
  input logic [NUM_IRQ-1:0]  irq_pending_i,
  input logic [NUM_IRQ-1:0]  irq_enable_i,
  input logic [NUM_MEM-1:0]  mem_req_i,
  input logic [NUM_PIPE-1:0] pipe_en_o,
  input logic                periph_en_o,
  input logic [NUM_MEM-1:0]  mem_en_o,
  input logic                wait_mode_o
);
  localparam logic [NUM_PIPE-1:0] ALL_PIPE  = {NUM_PIPE{1'b1}};
  localparam logic [NUM_PIPE-1:0] KEEP_MASK = ALL_PIPE >> (NUM_PIPE - STALL_KEEP);

  logic wake, in_run, in_enter;
  assign wake     = |(irq_pending_i & irq_enable_i);
  assign in_run   = (pipe_en_o == ALL_PIPE);
  assign in_enter = (pipe_en_o == '0) && periph_en_o && !wait_mode_o;

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run && !stall_i && wait_req_i && drained_i && !wake |=> in_enter);

  a_r3_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run && !stall_i && (wake || !drained_i) |=> in_run);

  a_r4_enter_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_enter |=> wait_mode_o);

  a_r4_dormant_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_mode_o |-> (pipe_en_o == '0) && !periph_en_o);

  a_r5_mem_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_mode_o |=> ((mem_en_o & $past(mem_req_i)) == $past(mem_req_i)));

  a_r6_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_mode_o && wake |=> !wait_mode_o);

  a_r7_wake_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_mode_o && wake && stall_i |=> (pipe_en_o == KEEP_MASK) && periph_en_o);

  a_r9_stall_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_mode_o && !wake |=> wait_mode_o);

  a_r10_stall_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run && stall_i |=> (pipe_en_o == KEEP_MASK));
endmodule

bind wait_clk_ctrl wait_clk_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_PIPE(NUM_PIPE), .STALL_KEEP(STALL_KEEP), .NUM_MEM(NUM_MEM)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .wait_req_i(wait_req_i),
  .drained_i(drained_i), .irq_pending_i(irq_pending_i), .irq_enable_i(irq_enable_i),
  .mem_req_i(mem_req_i), .pipe_en_o(pipe_en_o), .periph_en_o(periph_en_o),
  .mem_en_o(mem_en_o), .wait_mode_o(wait_mode_o)
);

// File: tb/test_wait_clk_ctrl.sv
module test_wait_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8, NP = 4, NK = 1, NM = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stall = 0, wreq = 0, drained = 0;
  logic [NI-1:0] irq_p = '0, irq_e = '0;
  logic [NM-1:0] mreq = '0;
  logic [NP-1:0] pipe_en;
  logic periph_en, wait_mode;
  logic [NM-1:0] mem_en;

  int checks = 0, errors = 0, cycles = 0;
  int st = 0;                 // 0 run, 1 stalled, 2 entering, 3 wait
  logic [NM-1:0] mem_exp = '1;
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_clk_ctrl #(.NUM_IRQ(NI), .NUM_PIPE(NP), .STALL_KEEP(NK), .NUM_MEM(NM)) i_wait_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall), .wait_req_i(wreq), .drained_i(drained),
    .irq_pending_i(irq_p), .irq_enable_i(irq_e), .mem_req_i(mreq),
    .pipe_en_o(pipe_en), .periph_en_o(periph_en), .mem_en_o(mem_en), .wait_mode_o(wait_mode)
  );

  function automatic logic [NP-1:0] exp_pipe(int s);
    if (s == 0) return '1;
    if (s == 1) return NP'((1 << NK) - 1);
    return '0;
  endfunction

  task automatic compare();
    logic [NP+NM+1:0] act, exp;
    act = {pipe_en, periph_en, mem_en, wait_mode};
    exp = {exp_pipe(st), 1'(st != 3), mem_exp, 1'(st == 3)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pipe,periph,mem,wait} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    logic wake;
    @(posedge clk);
    cycles++;
    wake = |(irq_p & irq_e);
    case (st)
      0: if (stall) st = 1; else if (wreq && drained && !wake) st = 2;
      1: if (!stall) st = 0;
      2: st = 3;
      default: if (wake) st = stall ? 1 : 0;
    endcase
    mem_exp = (st == 3) ? mreq : '1;
    @(negedge clk);
    compare();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic enter_wait();
    drained = 1; wreq = 1; stall = 0; irq_p = '0;
    step();            // -> entering
    wreq = 0;
    step();            // -> wait
  endtask

  initial begin
    logic [15:0] lfsr;
    #(CLK_PERIOD*2 + 1);
    req = "R1"; compare();
    @(negedge clk); rst_ni = 1'b1;
    steps(2);

    req = "R8"; stall = 1; steps(3); stall = 0; steps(2);
    req = "R10"; stall = 1; wreq = 1; drained = 1; steps(2); stall = 0; wreq = 0; steps(1);

    req = "R3"; drained = 0; wreq = 1; steps(3);
    drained = 1; irq_e = 8'h10; irq_p = 8'h10; steps(3);
    wreq = 0; irq_p = '0; steps(1);

    req = "R2"; irq_e = 8'h01; irq_p = 8'h80; drained = 1; wreq = 1; step();
    wreq = 0; irq_p = '0;
    req = "R4"; steps(3);
    req = "R5"; mreq = 2'b01; steps(2); mreq = 2'b10; step(); mreq = 2'b11; step(); mreq = 2'b00; steps(2);
    req = "R9"; stall = 1; steps(2); stall = 0; step(); stall = 1; step();
    req = "R6"; irq_p = 8'h02; steps(2);       // masked line, no wake
    req = "R7"; irq_p = 8'h01; step();          // wake with stall high -> stalled
    irq_p = '0; steps(2); stall = 0; steps(2);

    enter_wait();
    req = "R6"; mreq = 2'b10; irq_p = 8'h01; step(); irq_p = '0; mreq = 0; steps(2);
    req = "R7"; enter_wait(); stall = 0; irq_p = 8'h01; step(); irq_p = '0; steps(1);

    req = "R5"; lfsr = 16'hace1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall   = (lfsr[2:0] == 3'd0);
      wreq    = lfsr[3];
      drained = lfsr[4] | lfsr[5];
      irq_e   = {4'h0, lfsr[9:6]};
      irq_p   = (lfsr[12:10] == 3'd0) ? {4'h0, lfsr[15:12]} : '0;
      mreq    = lfsr[14:13];
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule